// File: doc/BRIEF.md
# Sync-Qualified Receive Word Queue

This block buffers received 12-bit data words in a 32-entry first-in first-out queue. A word is taken in only when the upstream framing logic reports that the channel is locked to its frame pattern, or when a bypass mode is on that accepts every word whatever the lock state. Words leave through a simple read port: a read request pops the oldest word into a registered output.

Alongside the data the block packs an 8-bit status byte. It carries the lock indicator, a 2-bit code naming the most recent frame marker, and occupancy flags for full, exactly half, empty and overflow. An overflow also drives a dedicated output pin. A synchronous software reset empties the queue and clears the overflow flag. Losing lock stops new words from coming in, but words already stored can still be read out.

Top module: `rxq_sync_buffer`

## Requirements
- R1: The queue holds at most 32 words. Status bit 4 (full) is 1 exactly when 32 words are stored.
- R2: Status bit 3 (half) is 1 only when the occupancy is exactly 16. It is 0 for 15, for 17 and for every other count.
- R3: After reset, status bit 2 (empty) is 1 and rd_data is 0. Bit 2 goes to 0 on the clock edge that stores the first accepted word.
- R4: An accepted write while the queue is full, with no read in the same cycle, is discarded. It sets status bit 1 (overflow) and `ovf_out` on the next edge.
- R5: Overflow stays set until `soft_rst` or `ovf_clr` is high at an edge. A new overflow in the same cycle as `ovf_clr` leaves it set.
- R6: A write is accepted only when `in_sync` or `bypass` is 1. Otherwise `wr_valid` has no effect on contents or flags.
- R7: When `in_sync` falls, words already stored stay readable in order.
- R8: A read while the queue is empty leaves `rd_data` and the occupancy unchanged.
- R9: A read and an accepted write in the same cycle while full both take effect. The queue stays full and overflow is not set.
- R10: `soft_rst` empties the queue and clears overflow, and it takes priority over any read or write in the same cycle. It leaves the marker code unchanged.
- R11: Status bit 7 follows `in_sync`. Bits 6-5 hold the `mark_code` value captured on the last `mark_strobe` edge, 0 after reset. Bit 0 is always 0.
- R12: Words come out in the order they were accepted. `rd_data` shows the popped word from the edge that performs the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous queue flush and overflow clear |
| in_sync | input | 1 | Lock indicator from the framing logic |
| bypass | input | 1 | Accept all words regardless of lock |
| mark_strobe | input | 1 | Capture `mark_code` |
| mark_code | input | 2 | Code of the frame marker just seen |
| wr_valid | input | 1 | Incoming word present |
| wr_data | input | 12 | Incoming word |
| rd_en | input | 1 | Pop request |
| rd_data | output | 12 | Last popped word |
| ovf_clr | input | 1 | Clear the overflow flag |
| status | output | 8 | Packed lock, marker code and occupancy flags |
| ovf_out | output | 1 | Overflow flag pin |

## Verification
The bench builds the block with its default parameters: 12-bit words and a depth of 32. At that depth the exact-half point at 16 and the full point at 32 are both reached by a few dozen directed writes. Those writes also hit the counts on either side of each point. The random phase favours writes while locked, so the queue keeps reaching full, and it overlaps reads, writes, clear strobes and flushes at that boundary.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // Advance a pointer with wrap at depth (works for non-power-of-two depths)
  function automatic logic [15:0] ptr_step(input logic [15:0] ptr, input int unsigned depth);
    if (ptr == 16'(depth - 1)) return 16'd0;
    return ptr + 16'd1;
  endfunction

  // Assemble the status byte from its fields
  function automatic logic [7:0] pack_status(input logic sync_i, input logic [1:0] code,
                                             input logic full, input logic half,
                                             input logic empty, input logic ovf);
    return {sync_i, code, full, half, empty, ovf, 1'b0};
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_req,
  input  logic             rd_en,
  input  logic             ovf_clr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             push,
  output logic             pop,
  output logic             drop,
  output logic             ovf
);
  import rxq_pkg::*;

  logic is_full;
  logic is_empty;

  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);

  // A pop frees a slot in the same cycle, so a full queue may still take a word
  assign pop  = rd_en & ~is_empty & ~soft_rst;
  assign push = wr_req & (~is_full | pop) & ~soft_rst;
  assign drop = wr_req & is_full & ~pop & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (soft_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ptr_step(16'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ptr_step(16'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf <= 1'b0;
    else if (soft_rst) ovf <= 1'b0;
    else if (drop)     ovf <= 1'b1;
    else if (ovf_clr)  ovf <= 1'b0;
  end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_data <= '0;
    else if (pop) rd_data <= mem[rd_ptr];
  end

endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sync,
  input  logic             mark_strobe,
  input  logic [1:0]       mark_code,
  input  logic [CNT_W-1:0] count,
  input  logic             ovf,
  output logic [7:0]       status
);
  import rxq_pkg::*;

  logic [1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           code_q <= 2'b00;
    else if (mark_strobe) code_q <= mark_code;
  end

  assign status = pack_status(in_sync, code_q,
                              count == CNT_W'(DEPTH),
                              count == CNT_W'(DEPTH / 2),
                              count == '0,
                              ovf);

endmodule

// File: rtl/rxq_sync_buffer.sv
module rxq_sync_buffer #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              in_sync,
  input  logic              bypass,
  input  logic              mark_strobe,
  input  logic [1:0]        mark_code,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ovf_clr,
  output logic [7:0]        status,
  output logic              ovf_out
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             wr_req;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push;
  logic             pop;
  logic             drop;
  logic             ovf;

  // Qualified write request: lock or bypass must be present
  assign wr_req = wr_valid & (in_sync | bypass);

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_req(wr_req),
    .rd_en(rd_en), .ovf_clr(ovf_clr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .push(push), .pop(pop), .drop(drop), .ovf(ovf)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .wr_data(wr_data), .rd_data(rd_data)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .mark_strobe(mark_strobe),
    .mark_code(mark_code), .count(count), .ovf(ovf), .status(status)
  );

  assign ovf_out = ovf;

endmodule

// File: rtl/rxq_sync_buffer_chk.sv
module rxq_sync_buffer_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              in_sync,
  input logic              bypass,
  input logic              wr_valid,
  input logic              rd_en,
  input logic              ovf_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic [7:0]        status,
  input logic              ovf_out,
  input logic [CNT_W-1:0]  count,
  input logic              push,
  input logic              pop,
  input logic              drop
);
  // R1: occupancy never exceeds the depth
  a_r1_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R2: stepping from 15 to 16 raises the half flag
  a_r2_half: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH / 2 - 1) && push && !pop) |=> status[3]);

  // R4: a discarded write raises overflow
  a_r4_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (ovf_out && status[1]));

  // R5: overflow holds without a clear source
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_out && !soft_rst && !ovf_clr) |=> ovf_out);

  // R6: without lock or bypass, a write cannot change occupancy
  a_r6_unsynced_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !bypass && !rd_en && !soft_rst) |=> $stable(count));

  // R8: reading an empty queue keeps the output word
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && rd_en && !soft_rst) |=> $stable(rd_data));

  // R9: read plus accepted write at full keeps it full, no new overflow
  a_r9_full_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && rd_en && wr_valid && (in_sync || bypass) && !soft_rst && !ovf_out)
      |=> (status[4] && !ovf_out));

  // R10: flush empties and clears overflow
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status[2] && !ovf_out));

  // R11: spare status bit stays low
  always_comb begin
    if (rst_n) a_r11_bit0: assert (status[0] == 1'b0);
  end

endmodule

bind rxq_sync_buffer rxq_sync_buffer_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_sync(in_sync),
  .bypass(bypass), .wr_valid(wr_valid), .rd_en(rd_en), .ovf_clr(ovf_clr),
  .rd_data(rd_data), .status(status), .ovf_out(ovf_out), .count(count),
  .push(push), .pop(pop), .drop(drop)
);

// File: tb/rxq_sync_buffer_test.sv
`timescale 1ns/1ps
module rxq_sync_buffer_test;
  localparam int DW = 12;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, in_sync = 0, bypass = 0, mark_strobe = 0;
  logic [1:0] mark_code = 0;
  logic wr_valid = 0, rd_en = 0, ovf_clr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] rd_data;
  logic [7:0] status;
  logic ovf_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [DW-1:0] mq[$];
  logic [DW-1:0] m_rd = '0;
  logic [1:0] m_code = 2'b00;
  logic m_ovf = 1'b0;

  always #2.5 clk = ~clk;

  rxq_sync_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_sync(in_sync),
    .bypass(bypass), .mark_strobe(mark_strobe), .mark_code(mark_code),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ovf_clr(ovf_clr), .status(status), .ovf_out(ovf_out)
  );

  function automatic logic [7:0] exp_status();
    int n = mq.size();
    return {in_sync, m_code, n == DEPTH, n == DEPTH / 2, n == 0, m_ovf, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference update from the requirements, applied at each edge
  task automatic model_edge();
    bit acc = wr_valid && (in_sync || bypass);
    bit full = (mq.size() == DEPTH);
    bit do_rd, do_wr;
    if (mark_strobe) m_code = mark_code;
    if (soft_rst) begin
      mq.delete();
      m_ovf = 1'b0;
    end else begin
      do_rd = rd_en && mq.size() > 0;
      do_wr = acc && (!full || do_rd);
      if (do_rd) m_rd = mq.pop_front();
      if (do_wr) mq.push_back(wr_data);
      if (acc && full && !do_rd) m_ovf = 1'b1;
      else if (ovf_clr) m_ovf = 1'b0;
    end
  endtask

  task automatic compare_all();
    logic [7:0] e = exp_status();
    chk("R1 full", status[4], e[4]);
    chk("R2 half", status[3], e[3]);
    chk("R3 empty", status[2], e[2]);
    chk("R5 ovf bit", status[1], e[1]);
    chk("R4 ovf pin", ovf_out, e[1]);
    chk("R11 sync/code/bit0", {status[7:5], status[0]}, {e[7:5], e[0]});
    chk("R12 rd_data", rd_data, m_rd);
  endtask

  // Inputs already set; run one edge and compare at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    wr_valid = 0; rd_en = 0; soft_rst = 0; ovf_clr = 0; mark_strobe = 0;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_valid = 1; wr_data = d; step();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R3 reset status", status, 8'h04);
    chk("R3 reset rd_data", rd_data, '0);
    rst_n = 1;
    @(negedge clk);

    // R6: no lock, no bypass -> ignored
    for (int i = 0; i < 3; i++) wr(12'(100 + i));
    chk("R6 unsynced empty", status[2], 1'b1);
    // R6: bypass accepts
    bypass = 1; wr(12'h0A5); bypass = 0;
    chk("R6 bypass accepted", status[2], 1'b0);

    // Fill to exactly half, then to full
    in_sync = 1;
    for (int i = 1; i < 15; i++) wr(12'(i));
    chk("R2 at 15 not half", status[3], 1'b0);
    wr(12'h00F);
    chk("R2 at 16 half", status[3], 1'b1);
    wr(12'h010);
    chk("R2 at 17 not half", status[3], 1'b0);
    for (int i = 17; i < 32; i++) wr(12'(i));
    chk("R1 full at 32", status[4], 1'b1);

    // R4 overflow on write while full
    wr(12'hFFF);
    chk("R4 overflow set", ovf_out, 1'b1);
    chk("R1 still full", status[4], 1'b1);
    // R5 sticky then clear; set beats clear
    step();
    chk("R5 sticky", ovf_out, 1'b1);
    wr_valid = 1; wr_data = 12'hEEE; ovf_clr = 1; step();
    chk("R5 set wins over clear", ovf_out, 1'b1);
    ovf_clr = 1; step();
    chk("R5 cleared", ovf_out, 1'b0);

    // R9 simultaneous read and write while full
    rd_en = 1; wr(12'h123);
    chk("R9 still full", status[4], 1'b1);
    chk("R9 no overflow", ovf_out, 1'b0);
    chk("R12 first word out", rd_data, 12'h0A5);

    // R7 lock lost: drain everything in order
    in_sync = 0;
    mark_code = 2'b10; mark_strobe = 1; step();
    while (status[2] == 1'b0) begin rd_en = 1; step(); end
    chk("R7 last word drained", rd_data, 12'h123);

    // R8 read on empty holds output
    held = rd_data;
    rd_en = 1; step();
    chk("R8 empty read holds", rd_data, held);
    chk("R8 still empty", status[2], 1'b1);

    // R10 flush beats write, keeps marker code
    in_sync = 1;
    wr(12'h111); wr(12'h222);
    wr_valid = 1; wr_data = 12'h333; soft_rst = 1; rd_en = 1; step();
    chk("R10 flushed empty", status[2], 1'b1);
    chk("R10 code kept", status[6:5], 2'b10);
    chk("R10 rd_data untouched", rd_data, held);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      in_sync     = ($urandom % 8) != 0;
      bypass      = ($urandom % 16) == 0;
      wr_valid    = ($urandom % 4) != 0;
      wr_data     = 12'($urandom);
      rd_en       = ($urandom % 3) == 0;
      ovf_clr     = ($urandom % 20) == 0;
      soft_rst    = ($urandom % 300) == 0;
      mark_strobe = ($urandom % 10) == 0;
      mark_code   = 2'($urandom);
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule